// File: doc/BRIEF.md
# Link Training Supervisor with Speed Fallback

This block sits beside a PCI Express style controller and decides, after training has been kicked off elsewhere, whether the link reached its active state. A start pulse makes it save the current link capability word and sample the 6-bit training state code once. If the code already shows the active state, the block reports success at once.

If the first sample is short of the active state, the block retries at the lowest generation. It writes a copy of the saved capability word whose speed field is forced to generation 1. It then waits a fixed settle time, given in clock cycles, and samples the code a second time. After that second sample it writes the saved word back unchanged, whatever the outcome.

Each capability write leaves the block on a valid/ready channel. `cap_wr_valid` rises with the word on `cap_out`, and both stay unchanged until `cap_wr_ready` is seen high at a rising edge. That edge completes the transfer, and the block does not move on until it happens. After a successful check the block also reports the negotiated link width and speed, taken from a link status word.

Top module: `link_train_supervisor`

## Requirements
- R1: After reset `busy`, `done`, `link_up`, `link_fail` and `cap_wr_valid` are all 0.
- R2: A `start` seen in idle is followed by one sample of `train_code` at the next rising edge. A code of 0x11 or more (unsigned, 6 bits) sets `link_up` and raises `done` in the cycle after that edge, and no capability write takes place.
- R3: A first sample below 0x11 raises `cap_wr_valid` with `cap_out` equal to the saved word, except that bits 3:0 are 0x1.
- R4: While `cap_wr_valid` is 1 and `cap_wr_ready` is 0, `cap_wr_valid` stays 1 and `cap_out` does not change. The transfer takes place at an edge where both are 1.
- R5: After the downgrade transfer the block waits exactly SETTLE_CYCLES cycles, ignoring `train_code` throughout. It then samples the code in the next cycle.
- R6: The second sample sets `link_up` when the code is 0x11 or more, and `link_fail` otherwise. `link_fail` never rises unless both samples were below 0x11.
- R7: After the second sample the block writes the saved word back unchanged, whatever the outcome. `done` rises in the cycle after that write transfers.
- R8: On success `link_width` holds status bits 9:4 and `link_speed` holds status bits 3:0, both latched at the sample that succeeded. On failure both are 0.
- R9: `start` has no effect while `busy` is 1. `cap_in` is read only when a start is accepted.
- R10: `done` is a single-cycle pulse. `link_up` and `link_fail` hold their values until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one supervision sequence |
| train_code | input | CODE_W | Training state code from the PHY/MAC |
| link_stat | input | WIDTH_LO+WIDTH_W | Link status word: width at bits 9:4, speed at bits 3:0 |
| cap_in | input | CAP_W | Current link capability word |
| cap_out | output | CAP_W | Capability word to be written |
| cap_wr_valid | output | 1 | Capability write pending |
| cap_wr_ready | input | 1 | Capability write accepted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| link_up | output | 1 | Link reached the active state |
| link_fail | output | 1 | Both samples were short of the active state |
| link_width | output | WIDTH_W | Latched link width |
| link_speed | output | SPD_W | Latched link speed |

## Verification
The assertions assume that `cap_wr_ready` eventually rises while a write is pending. They also assume that reset is applied before the first start. They place no constraint on `train_code` or `start`. The stimulus holds ready low for zero to three cycles at random before each transfer. It pulses `start` and changes `cap_in` while the block is busy. During the settle window it drives a code of the opposite class to the final one, so a sample taken too early changes the result.

// File: rtl/lts_pkg.sv
package lts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK1,
    ST_DGRADE,
    ST_WAIT,
    ST_CHECK2,
    ST_RESTORE,
    ST_DONE
  } lts_state_e;

endpackage

// File: rtl/lts_code_judge.sv
module lts_code_judge #(
  parameter int CODE_W      = 6,
  parameter int ACTIVE_CODE = 17,
  parameter int SPD_W       = 4,
  parameter int WIDTH_LO    = 4,
  parameter int WIDTH_W     = 6
) (
  input  logic [CODE_W-1:0]           train_code,
  input  logic [WIDTH_LO+WIDTH_W-1:0] link_stat,
  output logic                        active,
  output logic [WIDTH_W-1:0]          width_f,
  output logic [SPD_W-1:0]            speed_f
);

  localparam logic [CODE_W-1:0] ACTIVE_V = CODE_W'(ACTIVE_CODE);

  // Any code below the active state counts as "not up".
  assign active  = (train_code >= ACTIVE_V);
  assign width_f = link_stat[WIDTH_LO +: WIDTH_W];
  assign speed_f = link_stat[SPD_W-1:0];

endmodule

// File: rtl/lts_settle_timer.sv
module lts_settle_timer #(
  parameter int SETTLE_CYCLES = 3_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_V;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lts_cap_path.sv
module lts_cap_path #(
  parameter int CAP_W     = 32,
  parameter int SPD_W     = 4,
  parameter int LOW_SPEED = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CAP_W-1:0] cap_in,
  input  logic             drive,
  input  logic             sel_restore,
  output logic [CAP_W-1:0] cap_out,
  output logic             cap_wr_valid,
  input  logic             cap_wr_ready,
  output logic             xfer
);

  localparam logic [SPD_W-1:0] LOW_V = SPD_W'(LOW_SPEED);

  logic [CAP_W-1:0] saved_q;
  logic [CAP_W-1:0] lowered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_q <= '0;
    end else if (capture) begin
      saved_q <= cap_in;
    end
  end

  // Speed field forced low, every other bit taken from the saved word.
  for (genvar i = 0; i < CAP_W; i++) begin : g_low
    if (i < SPD_W) begin : g_spd
      assign lowered[i] = LOW_V[i];
    end else begin : g_keep
      assign lowered[i] = saved_q[i];
    end
  end

  assign cap_out      = sel_restore ? saved_q : lowered;
  assign cap_wr_valid = drive;
  assign xfer         = drive & cap_wr_ready;

  // R4: a stalled write keeps its valid and its data
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_wr_valid && !cap_wr_ready) |=> (cap_wr_valid && $stable(cap_out)));

endmodule

// File: rtl/link_train_supervisor.sv
module link_train_supervisor
  import lts_pkg::*;
#(
  parameter int CODE_W        = 6,
  parameter int CAP_W         = 32,
  parameter int SPD_W         = 4,
  parameter int WIDTH_LO      = 4,
  parameter int WIDTH_W       = 6,
  parameter int ACTIVE_CODE   = 17,
  parameter int LOW_SPEED     = 1,
  parameter int SETTLE_CYCLES = 3_000_000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CODE_W-1:0]           train_code,
  input  logic [WIDTH_LO+WIDTH_W-1:0] link_stat,
  input  logic [CAP_W-1:0]            cap_in,
  output logic [CAP_W-1:0]            cap_out,
  output logic                        cap_wr_valid,
  input  logic                        cap_wr_ready,
  output logic                        busy,
  output logic                        done,
  output logic                        link_up,
  output logic                        link_fail,
  output logic [WIDTH_W-1:0]          link_width,
  output logic [SPD_W-1:0]            link_speed
);

  localparam int CHK_W = $clog2(SETTLE_CYCLES + 1) + 1;

  lts_state_e state_q, state_d;

  logic               active;
  logic [WIDTH_W-1:0] width_f;
  logic [SPD_W-1:0]   speed_f;
  logic               expired;
  logic               xfer;
  logic               accept;
  logic               drive;

  lts_code_judge #(
    .CODE_W(CODE_W), .ACTIVE_CODE(ACTIVE_CODE), .SPD_W(SPD_W),
    .WIDTH_LO(WIDTH_LO), .WIDTH_W(WIDTH_W)
  ) u_judge (
    .train_code(train_code), .link_stat(link_stat),
    .active(active), .width_f(width_f), .speed_f(speed_f)
  );

  lts_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load((state_q == ST_DGRADE) && xfer),
    .run(state_q == ST_WAIT),
    .expired(expired)
  );

  lts_cap_path #(.CAP_W(CAP_W), .SPD_W(SPD_W), .LOW_SPEED(LOW_SPEED)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .capture(accept), .cap_in(cap_in),
    .drive(drive), .sel_restore(state_q == ST_RESTORE),
    .cap_out(cap_out), .cap_wr_valid(cap_wr_valid),
    .cap_wr_ready(cap_wr_ready), .xfer(xfer)
  );

  assign accept = (state_q == ST_IDLE) && start;
  assign drive  = (state_q == ST_DGRADE) || (state_q == ST_RESTORE);
  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_CHECK1;
      ST_CHECK1:  state_d = active ? ST_DONE : ST_DGRADE;
      ST_DGRADE:  if (xfer) state_d = ST_WAIT;
      ST_WAIT:    if (expired) state_d = ST_CHECK2;
      ST_CHECK2:  state_d = ST_RESTORE;
      ST_RESTORE: if (xfer) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Result registers: cleared on an accepted start, set at a deciding sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_up    <= 1'b0;
      link_fail  <= 1'b0;
      link_width <= '0;
      link_speed <= '0;
    end else if (accept) begin
      link_up    <= 1'b0;
      link_fail  <= 1'b0;
      link_width <= '0;
      link_speed <= '0;
    end else if (((state_q == ST_CHECK1) || (state_q == ST_CHECK2)) && active) begin
      link_up    <= 1'b1;
      link_width <= width_f;
      link_speed <= speed_f;
    end else if (state_q == ST_CHECK2) begin
      link_fail  <= 1'b1;
    end
  end

  // Assertion-only bookkeeping
  logic [CHK_W-1:0] wait_seen_q;
  logic             retry_seen_q;
  logic             restore_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_seen_q    <= '0;
      retry_seen_q   <= 1'b0;
      restore_seen_q <= 1'b0;
    end else begin
      if (accept) begin
        retry_seen_q   <= 1'b0;
        restore_seen_q <= 1'b0;
      end
      if ((state_q == ST_DGRADE) && xfer) begin
        retry_seen_q <= 1'b1;
        wait_seen_q  <= '0;
      end else if ((state_q == ST_WAIT) && (wait_seen_q < CHK_W'(SETTLE_CYCLES))) begin
        wait_seen_q  <= wait_seen_q + 1'b1;
      end
      if ((state_q == ST_RESTORE) && xfer) restore_seen_q <= 1'b1;
    end
  end

  // R5: the second sample never comes before the full settle time
  a_r5_min_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK2) |-> (wait_seen_q >= CHK_W'(SETTLE_CYCLES)));

  // R6: failure only after a retry, and never together with success
  a_r6_fail_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> retry_seen_q);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up && link_fail));

  // R7: a retried sequence ends only after the restore write transferred
  a_r7_restored: assert property (@(posedge clk) disable iff (!rst_n)
    (done && retry_seen_q) |-> restore_seen_q);

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/link_train_supervisor_bench.sv
module link_train_supervisor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  train_code = '0;
  logic [9:0]  link_stat = '0;
  logic [31:0] cap_in = '0;
  logic [31:0] cap_out;
  logic        cap_wr_valid;
  logic        cap_wr_ready = 1'b0;
  logic        busy, done, link_up, link_fail;
  logic [5:0]  link_width;
  logic [3:0]  link_speed;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_train_supervisor #(.SETTLE_CYCLES(SETTLE)) u_link_train_supervisor (
    .clk(clk), .rst_n(rst_n), .start(start), .train_code(train_code),
    .link_stat(link_stat), .cap_in(cap_in), .cap_out(cap_out),
    .cap_wr_valid(cap_wr_valid), .cap_wr_ready(cap_wr_ready),
    .busy(busy), .done(done), .link_up(link_up), .link_fail(link_fail),
    .link_width(link_width), .link_speed(link_speed)
  );

  function automatic bit is_up(input logic [5:0] c);
    return c >= 6'h11;
  endfunction

  function automatic logic [31:0] lowered(input logic [31:0] c);
    return {c[31:4], 4'h1};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_xfer(input logic [31:0] exp_word, input string tag);
    int stall = int'($urandom % 4);
    for (int k = 0; k < stall; k++) begin
      start = 1'b1;                       // R9: ignored while busy
      cap_in = $urandom;
      @(negedge clk);
      chk(cap_wr_valid === 1'b1, {tag, " R4 valid held"}, 32'(cap_wr_valid), 32'd1);
      chk(cap_out === exp_word, {tag, " R4 data held"}, cap_out, exp_word);
    end
    start = 1'b0;
    cap_wr_ready = 1'b1;
    @(negedge clk);
    cap_wr_ready = 1'b0;
  endtask

  task automatic run_case(input logic [31:0] cap, input logic [5:0] c1,
                          input logic [5:0] c2, input logic [9:0] st);
    logic exp_up;
    @(negedge clk);
    cap_in = cap; train_code = c1; link_stat = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", 32'(busy), 32'd1);
    chk(link_up === 1'b0 && link_fail === 1'b0, "R10 cleared by start",
        {30'd0, link_up, link_fail}, 32'd0);
    cap_in = $urandom;                    // R9: must not matter
    @(negedge clk);
    if (is_up(c1)) begin
      chk(link_up === 1'b1 && link_fail === 1'b0, "R2 first check up",
          {30'd0, link_up, link_fail}, 32'd2);
      chk(done === 1'b1, "R2 done", 32'(done), 32'd1);
      chk(cap_wr_valid === 1'b0, "R2 no write", 32'(cap_wr_valid), 32'd0);
      chk({link_width, link_speed} === st, "R8 width/speed",
          32'({link_width, link_speed}), 32'(st));
      @(negedge clk);
      chk(done === 1'b0 && link_up === 1'b1, "R10 pulse and hold",
          {30'd0, done, link_up}, 32'd1);
      return;
    end
    chk(cap_wr_valid === 1'b1, "R3 downgrade valid", 32'(cap_wr_valid), 32'd1);
    chk(cap_out === lowered(cap), "R3 downgrade word", cap_out, lowered(cap));
    wait_xfer(lowered(cap), "R3");
    exp_up = is_up(c2);
    train_code = exp_up ? 6'h05 : 6'h2A;  // opposite class during settle
    chk(cap_wr_valid === 1'b0, "R5 no write in wait", 32'(cap_wr_valid), 32'd0);
    for (int k = 0; k < SETTLE; k++) begin
      @(negedge clk);
      chk(cap_wr_valid === 1'b0 && link_up === 1'b0 && link_fail === 1'b0,
          "R5 settle window", {29'd0, cap_wr_valid, link_up, link_fail}, 32'd0);
    end
    train_code = c2;
    @(negedge clk);
    train_code = exp_up ? 6'h05 : 6'h2A;
    chk(link_up === exp_up && link_fail === !exp_up, "R6 second check",
        {30'd0, link_up, link_fail}, {30'd0, exp_up, !exp_up});
    chk({link_width, link_speed} === (exp_up ? st : 10'd0), "R8 width/speed",
        32'({link_width, link_speed}), 32'(exp_up ? st : 10'd0));
    chk(cap_wr_valid === 1'b1, "R7 restore valid", 32'(cap_wr_valid), 32'd1);
    chk(cap_out === cap, "R7 restore word", cap_out, cap);
    wait_xfer(cap, "R7");
    chk(done === 1'b1 && cap_wr_valid === 1'b0, "R7 done after restore",
        {30'd0, done, cap_wr_valid}, 32'd2);
    @(negedge clk);
    chk(done === 1'b0 && link_up === exp_up && link_fail === !exp_up,
        "R10 pulse and hold", {29'd0, done, link_up, link_fail},
        {29'd0, 1'b0, exp_up, !exp_up});
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && link_up === 0 && link_fail === 0 &&
        cap_wr_valid === 0, "R1 reset state",
        {27'd0, busy, done, link_up, link_fail, cap_wr_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && cap_wr_valid === 1'b0, "R1 idle after reset",
        {30'd0, busy, cap_wr_valid}, 32'd0);
    // Directed corner cases at the threshold and the extremes
    run_case(32'hA5A5_5A53, 6'h11, 6'h00, 10'h2A3);
    run_case(32'h1234_567F, 6'h10, 6'h11, 10'h0F2);
    run_case(32'hFFFF_FFFF, 6'h10, 6'h10, 10'h3FF);
    run_case(32'h0000_0000, 6'h00, 6'h3F, 10'h041);
    run_case(32'hDEAD_BEE2, 6'h3F, 6'h3F, 10'h105);
    for (int n = 0; n < 40; n++) begin
      run_case($urandom, 6'($urandom), 6'($urandom), 10'($urandom));
    end
    summary();
  end

endmodule